// File: doc/BRIEF.md
# SHA-2 Double-Round Compression Step

This block advances a SHA-2 working state by two consecutive compression rounds in one registered step. The eight working variables arrive split across two packed four-word operands. One operand carries the pair-variables c, d, g, h and the other carries a, b, e, f. A third four-word operand carries words that already hold the round constant plus the message-schedule word. Only its two lowest words are used: the lowest feeds the first round and the next feeds the second. The block returns the new a, b, e, f group in the same packing. The caller supplies the matching c, d, g, h for the next step.

A width input selects the word size. At 32 bits the block applies the SHA-256 round functions to the low 128 bits of each 256-bit operand. At 64 bits it applies the SHA-512 round functions to all 256 bits. Any other width is rejected with an error flag and leaves the result register untouched. A result appears one clock after each accepted input.

Top module: `sha2_pair_rounds`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` and `out_err` are 0 and `out_group` is all zeros.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1, and 0 in every other cycle.
- R3: Each operand holds four words in big-endian order, word 0 in the most significant position. `op_cdgh` holds c, d, g, h from the top down. `op_abef` holds a, b, e, f from the top down.
- R4: Each round computes T1 = h + S1(e) + Ch(e,f,g) + k and T2 = S0(a) + Maj(a,b,c), modulo 2^width. It then sets a=T1+T2, b=a, c=b, d=c, e=d+T1, f=e, g=f, h=g. The second round starts from the state left by the first.
- R5: When `word_bits` = 32, S0 = ROTR2^ROTR13^ROTR22 and S1 = ROTR6^ROTR11^ROTR25 on 32-bit words.
- R6: When `word_bits` = 64, S0 = ROTR28^ROTR34^ROTR39 and S1 = ROTR14^ROTR18^ROTR41 on 64-bit words.
- R7: In `op_kw`, the least significant word is the first round's k and the next word up is the second round's k. The two upper words have no effect on the result.
- R8: In 32-bit mode only bits [127:0] of each operand are used, and `out_group[255:127+1]` is driven to zero.
- R9: `out_group` holds a, b, e, f after both rounds, packed as in R3.
- R10: If `in_valid` = 1 and `word_bits` is neither 32 nor 64, the next cycle shows `out_valid` = 1 with `out_err` = 1, and `out_group` keeps its previous value.
- R11: `out_err` is 0 after any accepted input with a legal width, and is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and width are presented this cycle |
| word_bits | input | 7 | Word width select: 32 or 64, other values illegal |
| op_cdgh | input | 256 | Packed c, d, g, h group |
| op_abef | input | 256 | Packed a, b, e, f group |
| op_kw | input | 256 | Packed constant-plus-schedule words, low two used |
| out_valid | output | 1 | Result or error is present this cycle |
| out_err | output | 1 | Width select of the matching input was illegal |
| out_group | output | 256 | Updated a, b, e, f group |

## Verification
The bench uses hand-worked single-bit vectors in both widths, where only the first k is 1. A design with a wrong rotation amount or a wrong lane order gives a different constant pattern in a and e. A design that swapped the two k words puts the 1 into the wrong round and changes both words. Random operands are run with junk in the two upper k words and, in 32-bit mode, junk in the upper operand halves. A block that read those bits would change its result or leave non-zero upper output bits. Illegal widths on either side of the legal values are sent right after a legal result. A design that still wrote the register would lose that value, and one that forgot the flag would report success. Back-to-back and gapped inputs expose any extra or missing latency cycle.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;

   typedef enum logic [1:0] {
      WM_NARROW = 2'd0,
      WM_WIDE   = 2'd1,
      WM_BAD    = 2'd2
   } width_mode_e;

   // Map a requested word width to a datapath variant
   function automatic width_mode_e decode_width(input int unsigned bits,
                                                input int unsigned narrow,
                                                input int unsigned wide);
      if (bits == narrow)    return WM_NARROW;
      else if (bits == wide) return WM_WIDE;
      else                   return WM_BAD;
   endfunction

endpackage

// File: rtl/sha2r_round.sv
module sha2r_round #(
   parameter int W = 32
) (
   input  logic [8*W-1:0] st_i,
   input  logic [W-1:0]   kw_i,
   output logic [8*W-1:0] st_o
);
   localparam bool_wide = (W == 64);
   localparam int S0_A = bool_wide ? 28 : 2;
   localparam int S0_B = bool_wide ? 34 : 13;
   localparam int S0_C = bool_wide ? 39 : 22;
   localparam int S1_A = bool_wide ? 14 : 6;
   localparam int S1_B = bool_wide ? 18 : 11;
   localparam int S1_C = bool_wide ? 41 : 25;

   if (W != 32 && W != 64) begin : g_bad_w
      initial $fatal(1, "sha2r_round: W must be 32 or 64");
   end

   function automatic logic [W-1:0] rotr(input logic [W-1:0] x, input int n);
      return (x >> n) | (x << (W - n));
   endfunction

   logic [W-1:0] v [8];
   for (genvar k = 0; k < 8; k++) begin : g_unpack
      assign v[k] = st_i[(7-k)*W +: W];
   end

   logic [W-1:0] big_s0, big_s1, ch_w, maj_w, t1, t2;

   always_comb begin
      big_s1 = rotr(v[4], S1_A) ^ rotr(v[4], S1_B) ^ rotr(v[4], S1_C);
      big_s0 = rotr(v[0], S0_A) ^ rotr(v[0], S0_B) ^ rotr(v[0], S0_C);
      ch_w   = (v[4] & v[5]) ^ (~v[4] & v[6]);
      maj_w  = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
      t1     = v[7] + big_s1 + ch_w + kw_i;
      t2     = big_s0 + maj_w;
      st_o   = {t1 + t2, v[0], v[1], v[2], v[3] + t1, v[4], v[5], v[6]};
   end

endmodule

// File: rtl/sha2r_pair.sv
module sha2r_pair #(
   parameter int W      = 32,
   parameter int NWORDS = 4,
   parameter int ROUNDS = 2
) (
   input  logic [NWORDS*W-1:0] cdgh_i,
   input  logic [NWORDS*W-1:0] abef_i,
   input  logic [NWORDS*W-1:0] kw_i,
   output logic [NWORDS*W-1:0] abef_o
);
   localparam int STW = 8 * W;

   if (NWORDS != 4) begin : g_bad_nw
      initial $fatal(1, "sha2r_pair: NWORDS must be 4");
   end
   if (ROUNDS < 1 || ROUNDS > NWORDS) begin : g_bad_rounds
      initial $fatal(1, "sha2r_pair: ROUNDS out of range");
   end

   // Word k of a group (k = 0 most significant)
   function automatic logic [W-1:0] wd(input logic [NWORDS*W-1:0] g, input int k);
      return g[(NWORDS-1-k)*W +: W];
   endfunction

   logic [STW-1:0] st [ROUNDS+1];

   assign st[0] = {wd(abef_i, 0), wd(abef_i, 1), wd(cdgh_i, 0), wd(cdgh_i, 1),
                   wd(abef_i, 2), wd(abef_i, 3), wd(cdgh_i, 2), wd(cdgh_i, 3)};

   for (genvar r = 0; r < ROUNDS; r++) begin : g_round
      sha2r_round #(.W(W)) u_rnd (
         .st_i (st[r]),
         .kw_i (kw_i[r*W +: W]),
         .st_o (st[r+1])
      );
   end

   if (ROUNDS < NWORDS) begin : g_spare_kw
      logic unused_kw_hi;
      assign unused_kw_hi = ^kw_i[NWORDS*W-1:ROUNDS*W];
   end

   // State order is a,b,c,d,e,f,g,h from the top; keep a, b, e, f
   assign abef_o = {st[ROUNDS][8*W-1 -: 2*W], st[ROUNDS][4*W-1 -: 2*W]};

endmodule

// File: rtl/sha2_pair_rounds.sv
module sha2_pair_rounds
   import sha2r_pkg::*;
#(
   parameter int W_NARROW  = 32,
   parameter int W_WIDE    = 64,
   parameter int NUM_WORDS = 4,
   parameter int WB_BITS   = 7,
   localparam int GROUP_W  = NUM_WORDS * W_WIDE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WB_BITS-1:0] word_bits,
   input  logic [GROUP_W-1:0] op_cdgh,
   input  logic [GROUP_W-1:0] op_abef,
   input  logic [GROUP_W-1:0] op_kw,
   output logic               out_valid,
   output logic               out_err,
   output logic [GROUP_W-1:0] out_group
);
   localparam int NARROW_GW = NUM_WORDS * W_NARROW;
   localparam int PAD_W     = GROUP_W - NARROW_GW;

   if (W_NARROW != 32 || W_WIDE != 64) begin : g_bad_widths
      initial $fatal(1, "sha2_pair_rounds: word widths must be 32 and 64");
   end
   if ((1 << WB_BITS) <= W_WIDE) begin : g_bad_wb
      initial $fatal(1, "sha2_pair_rounds: WB_BITS too small for W_WIDE");
   end

   width_mode_e mode;
   assign mode = decode_width(int'(word_bits), W_NARROW, W_WIDE);

   // Narrow lane: low half of every operand
   logic [NARROW_GW-1:0] nar_res;
   sha2r_pair #(.W(W_NARROW), .NWORDS(NUM_WORDS)) u_nar (
      .cdgh_i (op_cdgh[NARROW_GW-1:0]),
      .abef_i (op_abef[NARROW_GW-1:0]),
      .kw_i   (op_kw[NARROW_GW-1:0]),
      .abef_o (nar_res)
   );

   // Wide lane: full operands
   logic [GROUP_W-1:0] wide_res;
   sha2r_pair #(.W(W_WIDE), .NWORDS(NUM_WORDS)) u_wide (
      .cdgh_i (op_cdgh),
      .abef_i (op_abef),
      .kw_i   (op_kw),
      .abef_o (wide_res)
   );

   logic [GROUP_W-1:0] sel_res;
   always_comb begin
      if (mode == WM_NARROW) sel_res = {{PAD_W{1'b0}}, nar_res};
      else                   sel_res = wide_res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_group <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid && (mode == WM_BAD);
         if (in_valid && mode != WM_BAD) out_group <= sel_res;
      end
   end

endmodule

// File: rtl/sha2_pair_rounds_chk.sv
module sha2_pair_rounds_chk #(
   parameter int WB_BITS = 7,
   parameter int GROUP_W = 256
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [WB_BITS-1:0] word_bits,
   input logic               out_valid,
   input logic               out_err,
   input logic [GROUP_W-1:0] out_group
);
   logic legal_w;
   assign legal_w = (word_bits == WB_BITS'(32)) || (word_bits == WB_BITS'(64));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal_w) |=> (out_err && $stable(out_group)));

   // R11
   legal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal_w) |=> !out_err);

   // R11
   err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);

   // R8
   narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && word_bits == WB_BITS'(32)) |=> (out_group[GROUP_W-1:GROUP_W/2] == '0));

endmodule

bind sha2_pair_rounds sha2_pair_rounds_chk #(.WB_BITS(WB_BITS), .GROUP_W(GROUP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .word_bits (word_bits),
   .out_valid (out_valid),
   .out_err   (out_err),
   .out_group (out_group)
);

// File: tb/sim_sha2_pair_rounds.sv
module sim_sha2_pair_rounds;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [6:0]   word_bits = 7'd32;
   logic [255:0] op_cdgh = '0, op_abef = '0, op_kw = '0;
   logic         out_valid, out_err;
   logic [255:0] out_group;

   always #5 clk = ~clk;

   sha2_pair_rounds u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .word_bits (word_bits),
      .op_cdgh (op_cdgh), .op_abef (op_abef), .op_kw (op_kw),
      .out_valid (out_valid), .out_err (out_err), .out_group (out_group)
   );

   typedef struct {
      logic [255:0] g;
      logic         e;
      int           cyc;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   int           checks = 0, fails = 0, cyc = 0;
   logic [255:0] last_grp = '0;
   bit           done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- reference model ----------------
   function automatic logic [63:0] msk(int w);
      return (w == 32) ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
   endfunction

   function automatic logic [63:0] rr(logic [63:0] x, int n, int w);
      logic [63:0] m = msk(w);
      x = x & m;
      return ((x >> n) | (x << (w - n))) & m;
   endfunction

   function automatic logic [63:0] wd(logic [255:0] v, int i, int w);
      logic [255:0] s = v >> ((3 - i) * w);
      return s[63:0] & msk(w);
   endfunction

   function automatic logic [255:0] ref_pair(int w, logic [255:0] cdgh,
                                             logic [255:0] abef, logic [255:0] kw);
      logic [63:0] m = msk(w);
      logic [63:0] a, b, c, d, e, f, g, h, k, s0, s1, ch, mj, t1, t2;
      logic [255:0] res;
      a = wd(abef, 0, w); b = wd(abef, 1, w); e = wd(abef, 2, w); f = wd(abef, 3, w);
      c = wd(cdgh, 0, w); d = wd(cdgh, 1, w); g = wd(cdgh, 2, w); h = wd(cdgh, 3, w);
      for (int r = 0; r < 2; r++) begin
         k  = wd(kw, 3 - r, w);
         s1 = (w == 32) ? (rr(e, 6, w) ^ rr(e, 11, w) ^ rr(e, 25, w))
                        : (rr(e, 14, w) ^ rr(e, 18, w) ^ rr(e, 41, w));
         s0 = (w == 32) ? (rr(a, 2, w) ^ rr(a, 13, w) ^ rr(a, 22, w))
                        : (rr(a, 28, w) ^ rr(a, 34, w) ^ rr(a, 39, w));
         ch = ((e & f) ^ (~e & g)) & m;
         mj = (a & b) ^ (a & c) ^ (b & c);
         t1 = (h + s1 + ch + k) & m;
         t2 = (s0 + mj) & m;
         h = g; g = f; f = e; e = (d + t1) & m;
         d = c; c = b; b = a; a = (t1 + t2) & m;
      end
      res = (256'(a) << (3 * w)) | (256'(b) << (2 * w)) | (256'(e) << w) | 256'(f);
      return res;
   endfunction

   function automatic logic [255:0] rand256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   // ---------------- driver ----------------
   task automatic drive_exp(int w, logic [255:0] cdgh, logic [255:0] abef,
                            logic [255:0] kw, logic [255:0] eg, bit ee, string tag);
      exp_t it;
      @(negedge clk);
      in_valid  = 1'b1;
      word_bits = 7'(w);
      op_cdgh   = cdgh;
      op_abef   = abef;
      op_kw     = kw;
      it.g = ee ? last_grp : eg;
      it.e = ee;
      it.cyc = cyc + 1;
      it.tag = tag;
      if (!ee) last_grp = eg;
      sb.push_back(it);
   endtask

   task automatic drive(int w, logic [255:0] cdgh, logic [255:0] abef,
                        logic [255:0] kw, string tag);
      drive_exp(w, cdgh, abef, kw, ref_pair(w, cdgh, abef, kw), 1'b0, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op_cdgh  = rand256();
      end
   endtask

   // ---------------- monitor / scoreboard ----------------
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            exp_t it;
            checks++;
            if (sb.size() == 0) begin
               fails++;
               $display("FAIL R2: out_valid=1 with nothing outstanding, expected 0");
            end else begin
               it = sb.pop_front();
               if (it.cyc != cyc) begin
                  fails++;
                  $display("FAIL R2 (%s): result at cycle %0d, expected %0d", it.tag, cyc, it.cyc);
               end else if (out_err !== it.e || out_group !== it.g) begin
                  fails++;
                  $display("FAIL %s: err=%0b group=%h, expected err=%0b group=%h",
                           it.tag, out_err, out_group, it.e, it.g);
               end
            end
         end else if (sb.size() != 0 && sb[0].cyc < cyc) begin
            checks++;
            fails++;
            $display("FAIL R2 (%s): out_valid=0 at cycle %0d, expected 1", sb[0].tag, cyc);
            void'(sb.pop_front());
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [255:0] c1, a1, k1, eg;
      in_valid = 1'b1;   // active input during reset must be ignored
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || out_group !== '0) begin
         fails++;
         $display("FAIL R1: in reset valid=%0b err=%0b group=%h, expected 0 0 0",
                  out_valid, out_err, out_group);
      end
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || out_group !== '0) begin
         fails++;
         $display("FAIL R1: after reset valid=%0b err=%0b group=%h, expected 0 0 0",
                  out_valid, out_err, out_group);
      end

      // R4 R5 R9: hand-worked 32-bit vector, only first k = 1
      drive_exp(32, '0, '0, 256'd1,
                {128'd0, 32'h4428_0480, 32'h1, 32'h0420_0080, 32'h1}, 1'b0, "R4/R5/R9 hand32");
      // R4 R6 R9: hand-worked 64-bit vector
      drive_exp(64, '0, '0, 256'd1,
                {64'h0004_4010_4280_0000, 64'h1, 64'h0004_4000_0080_0000, 64'h1},
                1'b0, "R4/R6/R9 hand64");
      // R7: second k alone differs from first k alone (order of k words)
      drive(32, '0, '0, {224'd0, 32'h1} << 32, "R7 second-k32");
      // R3 all-zero state stays zero
      drive(64, '0, '0, '0, "R3 zero64");
      idle(2);

      // R3 R5: random 32-bit back-to-back
      for (int i = 0; i < 20; i++)
         drive(32, {128'd0, rand256() >> 128}, {128'd0, rand256() >> 128},
               {128'd0, rand256() >> 128}, "R3/R5 rand32");
      // R3 R6: random 64-bit
      for (int i = 0; i < 20; i++)
         drive(64, rand256(), rand256(), rand256(), "R3/R6 rand64");
      idle(3);

      // R7: upper k words ignored (same expected for different upper words)
      c1 = rand256(); a1 = rand256(); k1 = rand256();
      eg = ref_pair(64, c1, a1, k1);
      drive_exp(64, c1, a1, k1, eg, 1'b0, "R7 kw-upper-a64");
      drive_exp(64, c1, a1, {rand256() >> 128, k1[127:0]} , eg, 1'b0, "R7 kw-upper-b64");
      eg = ref_pair(32, {128'd0, c1[127:0]}, {128'd0, a1[127:0]}, {128'd0, k1[127:0]});
      drive_exp(32, {128'd0, c1[127:0]}, {128'd0, a1[127:0]}, {192'd0, k1[63:0]},
                eg, 1'b0, "R7 kw-upper-a32");
      drive_exp(32, {128'd0, c1[127:0]}, {128'd0, a1[127:0]}, {128'd0, rand256() >> 192, k1[63:0]},
                eg, 1'b0, "R7 kw-upper-b32");
      // R8: junk in upper halves in 32-bit mode, output top half zero
      drive_exp(32, {rand256() >> 128, c1[127:0]}, {rand256() >> 128, a1[127:0]},
                {rand256() >> 128, k1[127:0]}, eg, 1'b0, "R8 upper-junk32");

      // R10: illegal widths after a legal result, output held and flagged
      drive_exp(0,   rand256(), rand256(), rand256(), '0, 1'b1, "R10 width0");
      drive_exp(16,  rand256(), rand256(), rand256(), '0, 1'b1, "R10 width16");
      drive_exp(33,  rand256(), rand256(), rand256(), '0, 1'b1, "R10 width33");
      drive_exp(127, rand256(), rand256(), rand256(), '0, 1'b1, "R10 width127");
      // R11: legal input right after illegal clears the flag
      drive(64, rand256(), rand256(), rand256(), "R11 legal-after-bad");
      drive_exp(63, rand256(), rand256(), rand256(), '0, 1'b1, "R10 width63");
      idle(1);
      drive(32, '0, {128'd0, rand256() >> 128}, 256'd7, "R11 legal32-after-gap");
      idle(4);

      // R2 R11: idle after drain, no valid and no error
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || sb.size() != 0) begin
         fails++;
         $display("FAIL R2: idle valid=%0b err=%0b pending=%0d, expected 0 0 0",
                  out_valid, out_err, sb.size());
      end

      done = 1;
      summary();
      $finish;
   end

endmodule